// File: doc/BRIEF.md
# Translation Table Entry Invalidator

This block executes a privileged command that marks a run of translation table entries as invalid and then asks for the TLB to be flushed. The command has two 64-bit operands and a 4-bit modifier. The first operand gives the table origin and the table type. The second operand gives the starting index, the entry count, a walk-suppress flag and a reserved field. When the walk runs, the block reads each 8-byte entry through a single-outstanding memory port. If the invalid bit of an entry is clear, the block sets it and writes the entry back. It ends the command with one flush pulse: either local only or broadcast to all processors.

The command is issued with a one-cycle `start` while `busy` is low. A `start` while `busy` is high is ignored. The block rejects a command issued outside privileged mode, and a command whose reserved operand bits are not all zero. A rejected command raises a one-cycle specification exception and makes no memory access and no flush.

The memory port works as a request/acknowledge stream under back-pressure. A request (`mem_rd` or `mem_wr`) stays asserted, with its address and write data held steady, until the cycle in which `mem_ack` is sampled high. The acknowledge may come after any number of cycles. The read data must be valid in the acknowledge cycle.

Top module: `tte_invalidator`

## Requirements
- R1: After reset, busy, done, spec_exc, flush_local, flush_global, mem_rd and mem_wr are all low.
- R2: If any of op2 bits 19:12 is set, the command ends in the cycle after start with spec_exc and done both high for one cycle. It makes no memory request and pulses no flush.
- R3: If privileged is low when start is sampled, the command is rejected exactly as in R2.
- R4: If op2 bit 11 is 1, the block makes no memory request and finishes in the cycle after start with done and one flush pulse.
- R5: When op2 bit 11 is 0, the walk processes op2[10:0]+1 consecutive entries (1 to 2048).
- R6: The table type is op1[3:2]. The starting index is 11 bits wide and is taken from op2[63:53] for type 3, op2[52:42] for type 2, op2[41:31] for type 1 and op2[30:20] for type 0.
- R7: Entry i is at address {op1[63:12],12'h000} + ((start+i) mod 2048)*8. The index wraps at 2048, and the 64-bit address is never truncated.
- R8: Every entry is read first. If bit 5 of the read data is set, no write follows. Otherwise the next request is a write to the same address with the read data OR 0x20.
- R9: The flush pulse comes in the done cycle. flush_local is used when modifier[0] is 1 and local_clr_en is 1; otherwise flush_global is used. Exactly one of the two pulses is given.
- R10: At most one memory request is active at a time: mem_rd and mem_wr are never both high. An unacknowledged request keeps its strobe, address and write data.
- R11: A start sampled while busy is high has no effect on the running walk, on its result or on the following idle state.
- R12: busy is high from the cycle after an accepted start through the single done cycle, and it is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue a command (taken only while busy is low) |
| privileged | input | 1 | Issuer runs in privileged mode |
| local_clr_en | input | 1 | Configuration: local-only flushing allowed |
| op1 | input | 64 | Table origin [63:12] and table type [3:2] |
| op2 | input | 64 | Index fields, reserved [19:12], suppress-walk [11], last offset [10:0] |
| modifier | input | 4 | Bit 0 requests a local-only flush |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| spec_exc | output | 1 | One-cycle specification exception |
| flush_local | output | 1 | One-cycle local TLB flush request |
| flush_global | output | 1 | One-cycle broadcast TLB flush request |
| mem_rd | output | 1 | Read request, held until acknowledged |
| mem_wr | output | 1 | Write request, held until acknowledged |
| mem_addr | output | 64 | Request address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request acknowledge |

## Verification
The walk is run with each of the four table types. Every index field of op2 is filled with a different value, so taking the field from the wrong position changes the addresses. Memory contents alternate between entries that are already invalid and entries that are still valid, which checks that writes are skipped and that the written data is correct. The acknowledge delays are pseudo-random, so a request that is not held steady is also caught. Other runs cover an index that wraps past 2047, a full 2048-entry walk over an origin above 4 GiB, a second walk over already-invalidated entries, the suppress-walk flag, both rejection causes, all three flush-selection combinations, and a stray start during a walk.

// File: rtl/tte_inv_pkg.sv
package tte_inv_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned IDX_W  = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_FLUSH,
    ST_REJECT
  } walk_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] origin;
    logic [IDX_W-1:0]  first_idx;
    logic [IDX_W-1:0]  last_ofs;
    logic              flush_only;
    logic              local_flush;
    logic              reject;
  } cmd_t;
endpackage

// File: rtl/tte_inv_decode.sv
module tte_inv_decode
  import tte_inv_pkg::*;
#(
  parameter int unsigned SEG_IDX_LSB = 20,
  parameter int unsigned MODE_BIT    = 11,
  parameter int unsigned RSVD_LSB    = 12,
  parameter int unsigned RSVD_W      = 8,
  parameter int unsigned ORIGIN_LSB  = 12,
  parameter int unsigned TYPE_LSB    = 2
) (
  input  logic [WORD_W-1:0] op1,
  input  logic [WORD_W-1:0] op2,
  input  logic              mod_local,
  input  logic              privileged,
  input  logic              local_clr_en,
  output cmd_t              cmd
);
  localparam int unsigned LEVELS = 4;

  logic [IDX_W-1:0] lvl_idx [LEVELS];
  logic [1:0]       tbl_type;
  logic             unused_op1_bits;

  // one candidate index per table level, each field IDX_W above the last
  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign lvl_idx[g] = op2[SEG_IDX_LSB + g*IDX_W +: IDX_W];
    end
  endgenerate

  assign tbl_type        = op1[TYPE_LSB +: 2];
  assign unused_op1_bits = ^{op1[ORIGIN_LSB-1:TYPE_LSB+2], op1[TYPE_LSB-1:0]};

  always_comb begin
    cmd.origin      = {op1[WORD_W-1:ORIGIN_LSB], {ORIGIN_LSB{1'b0}}};
    cmd.first_idx   = lvl_idx[tbl_type];
    cmd.last_ofs    = op2[IDX_W-1:0];
    cmd.flush_only  = op2[MODE_BIT];
    cmd.local_flush = mod_local & local_clr_en;
    cmd.reject      = !privileged || (|op2[RSVD_LSB +: RSVD_W]);
  end
endmodule

// File: rtl/tte_inv_agen.sv
module tte_inv_agen
  import tte_inv_pkg::*;
#(
  parameter int unsigned ENTRY_SHIFT = 3
) (
  input  logic [WORD_W-1:0] origin,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] addr
);
  logic [WORD_W-1:0] offset;

  // index wraps in its own width; the sum is kept at full address width
  assign offset = {{(WORD_W-IDX_W){1'b0}}, idx} << ENTRY_SHIFT;
  assign addr   = origin + offset;
endmodule

// File: rtl/tte_inv_walk.sv
module tte_inv_walk
  import tte_inv_pkg::*;
#(
  parameter int unsigned INV_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_t              cmd,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              spec_exc,
  output logic              flush_local,
  output logic              flush_global,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] origin_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [WORD_W-1:0] wdata_q
);
  localparam logic [WORD_W-1:0] INV_MASK = WORD_W'(1) << INV_BIT;

  walk_state_e      state_q;
  logic [IDX_W-1:0] remain_q;
  logic             local_q;
  logic             entry_done;

  // an entry is finished by an acked write, or an acked read of an invalid entry
  assign entry_done = mem_ack && ((state_q == ST_WRITE) ||
                                  (state_q == ST_READ && mem_rdata[INV_BIT]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      origin_q <= '0;
      idx_q    <= '0;
      remain_q <= '0;
      local_q  <= 1'b0;
      wdata_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            origin_q <= cmd.origin;
            idx_q    <= cmd.first_idx;
            remain_q <= cmd.last_ofs;
            local_q  <= cmd.local_flush;
            if (cmd.reject)          state_q <= ST_REJECT;
            else if (cmd.flush_only) state_q <= ST_FLUSH;
            else                     state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack && !mem_rdata[INV_BIT]) begin
            wdata_q <= mem_rdata | INV_MASK;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: ;
        ST_FLUSH, ST_REJECT: state_q <= ST_IDLE;
        default:             state_q <= ST_IDLE;
      endcase
      if (entry_done) begin
        if (remain_q == '0) begin
          state_q <= ST_FLUSH;
        end else begin
          remain_q <= remain_q - 1'b1;
          idx_q    <= idx_q + 1'b1;
          state_q  <= ST_READ;
        end
      end
    end
  end

  always_comb begin
    busy         = (state_q != ST_IDLE);
    done         = (state_q == ST_FLUSH) || (state_q == ST_REJECT);
    spec_exc     = (state_q == ST_REJECT);
    flush_local  = (state_q == ST_FLUSH) && local_q;
    flush_global = (state_q == ST_FLUSH) && !local_q;
    mem_rd       = (state_q == ST_READ);
    mem_wr       = (state_q == ST_WRITE);
  end
endmodule

// File: rtl/tte_invalidator.sv
module tte_invalidator
  import tte_inv_pkg::*;
#(
  parameter int unsigned INV_BIT     = 5,
  parameter int unsigned ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              privileged,
  input  logic              local_clr_en,
  input  logic [WORD_W-1:0] op1,
  input  logic [WORD_W-1:0] op2,
  input  logic [3:0]        modifier,
  output logic              busy,
  output logic              done,
  output logic              spec_exc,
  output logic              flush_local,
  output logic              flush_global,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  cmd_t              cmd;
  logic [WORD_W-1:0] origin_q;
  logic [IDX_W-1:0]  idx_q;
  logic              unused_mod_bits;

  assign unused_mod_bits = ^modifier[3:1];

  tte_inv_decode u_decode (
    .op1          (op1),
    .op2          (op2),
    .mod_local    (modifier[0]),
    .privileged   (privileged),
    .local_clr_en (local_clr_en),
    .cmd          (cmd)
  );

  tte_inv_walk #(.INV_BIT(INV_BIT)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cmd          (cmd),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .busy         (busy),
    .done         (done),
    .spec_exc     (spec_exc),
    .flush_local  (flush_local),
    .flush_global (flush_global),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .origin_q     (origin_q),
    .idx_q        (idx_q),
    .wdata_q      (mem_wdata)
  );

  tte_inv_agen #(.ENTRY_SHIFT(ENTRY_SHIFT)) u_agen (
    .origin (origin_q),
    .idx    (idx_q),
    .addr   (mem_addr)
  );
endmodule

// File: rtl/tte_invalidator_chk.sv
module tte_invalidator_chk #(
  parameter int unsigned INV_BIT = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        spec_exc,
  input logic        flush_local,
  input logic        flush_global,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [63:0] mem_addr,
  input logic [63:0] mem_wdata,
  input logic        mem_ack
);
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata) &&
                                          $stable(mem_rd) && $stable(mem_wr))); // R10
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_local, flush_global, spec_exc})); // R9
  AST_OUTCOME_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local || flush_global || spec_exc) |-> done); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R12
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R12
  AST_EXC_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    spec_exc |-> (!mem_rd && !mem_wr)); // R2
  AST_WRITE_MARKS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[INV_BIT]); // R8
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (busy && !done)); // R10
endmodule

bind tte_invalidator tte_invalidator_chk #(.INV_BIT(INV_BIT)) u_chk (.*);

// File: tb/tte_invalidator_bench.sv
module tte_invalidator_bench;
  logic        clk = 1'b0;
  logic        rst_n, start, privileged, local_clr_en;
  logic [63:0] op1, op2, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  modifier;
  logic        busy, done, spec_exc, flush_local, flush_global, mem_rd, mem_wr, mem_ack;

  always #5 clk = ~clk;

  tte_invalidator u_tte_invalidator (.*);

  typedef struct {
    bit          wr;
    logic [63:0] addr;
    logic [63:0] data;
  } acc_t;

  acc_t        expq[$];
  logic [63:0] mem [longint unsigned];
  int          n_chk = 0;
  int          n_err = 0;
  int unsigned rng   = 32'h1234_5678;
  int          dly   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] seed_val(input logic [63:0] a);
    logic [63:0] v;
    v    = {a[31:0] ^ 32'h3C5A_9E17, a[31:0]};
    v[5] = a[3];
    return v;
  endfunction

  function automatic logic [63:0] rd_mem(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return seed_val(a);
  endfunction

  // op2 with every index field filled by a distinct junk value, then the chosen one set (R6)
  function automatic logic [63:0] mk_op2(input int ttype, input int idx, input int last,
                                         input bit mode, input logic [7:0] rsvd);
    logic [63:0] v;
    v = 64'h9D3_4E7A_B1C5_6000 << 8;
    v[20 + ttype*11 +: 11] = idx[10:0];
    v[19:12] = rsvd;
    v[11]    = mode;
    v[10:0]  = last[10:0];
    return v;
  endfunction

  function automatic logic [63:0] mk_op1(input logic [63:0] origin, input int ttype);
    return (origin & ~64'hFFF) | (64'hAF3 & ~64'hC) | (64'(ttype) << 2);
  endfunction

  // memory responder: pseudo-random delay, checks each handshake against the model
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (rst_n && (mem_rd || mem_wr)) begin
        check(!(mem_rd && mem_wr), "R10", "both strobes", {mem_rd, mem_wr}, 2'b00);
        if (dly > 0) begin
          dly--;
        end else begin
          if (expq.size() == 0) begin
            check(1'b0, "R10", "unexpected request", mem_addr, '0);
          end else begin
            acc_t e;
            e = expq.pop_front();
            check(mem_wr == e.wr, "R8", "access kind", 64'(mem_wr), 64'(e.wr));
            check(mem_addr == e.addr, "R7", "address", mem_addr, e.addr);
            if (mem_wr && e.wr)
              check(mem_wdata == e.data, "R8", "write data", mem_wdata, e.data);
          end
          if (mem_wr) mem[mem_addr] = mem_wdata;
          else        mem_rdata = rd_mem(mem_addr);
          mem_ack = 1'b1;
          rng = rng * 32'd1103515245 + 32'd12345;
          dly = int'((rng >> 16) % 4);
        end
      end
    end
  end

  task automatic run_cmd(input logic [63:0] o1, input logic [63:0] o2, input logic [3:0] m,
                         input bit priv, input bit lclr, input bit poke, input string tag);
    int          ttype, idx, cnt, waited;
    logic [63:0] origin, a, v;
    bit          exp_exc, exp_loc;
    exp_exc = !priv || (|o2[19:12]);
    exp_loc = m[0] && lclr;
    if (!exp_exc && !o2[11]) begin
      ttype  = int'(o1[3:2]);
      idx    = int'(o2[20 + ttype*11 +: 11]);
      cnt    = int'(o2[10:0]) + 1;
      origin = o1 & ~64'hFFF;
      for (int i = 0; i < cnt; i++) begin
        a = origin + 64'(((idx + i) & 11'h7FF) * 8);
        v = rd_mem(a);
        expq.push_back('{wr: 1'b0, addr: a, data: '0});
        if (!v[5]) expq.push_back('{wr: 1'b1, addr: a, data: v | 64'h20});
      end
    end
    @(negedge clk);
    op1 = o1; op2 = o2; modifier = m; privileged = priv; local_clr_en = lclr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R12", {tag, " busy after start"}, 64'(busy), 64'd1);
    waited = 0;
    while (!done && waited < 40000) begin
      if (poke && waited == 3) begin
        start = 1'b1; op2 = 64'hFFFF_FFFF_FFFF_FFFF; privileged = 1'b0; // R11 stray start
      end else begin
        start = 1'b0; op2 = o2; privileged = priv;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    check(done == 1'b1, "R12", {tag, " completion"}, 64'(done), 64'd1);
    check(spec_exc == exp_exc, exp_exc ? "R2" : "R9", {tag, " exception"}, 64'(spec_exc), 64'(exp_exc));
    check(flush_local == (!exp_exc && exp_loc), "R9", {tag, " local flush"},
          64'(flush_local), 64'(!exp_exc && exp_loc));
    check(flush_global == (!exp_exc && !exp_loc), "R9", {tag, " global flush"},
          64'(flush_global), 64'(!exp_exc && !exp_loc));
    check(expq.size() == 0, "R5", {tag, " accesses left"}, 64'(expq.size()), 64'd0);
    expq.delete();
    @(negedge clk);
    check(!busy && !done, "R12", {tag, " idle after done"}, {busy, done}, 2'b00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R12 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; privileged = 1'b1; local_clr_en = 1'b1;
    op1 = '0; op2 = '0; modifier = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, done, spec_exc, flush_local, flush_global, mem_rd, mem_wr} == 7'b0, "R1",
          "outputs after reset", {busy, done, spec_exc, flush_local, flush_global, mem_rd, mem_wr}, '0);
    // R5 R6 R7 R8 R9: segment table, 4 entries, broadcast flush
    run_cmd(mk_op1(64'h0000_0000_0004_0000, 0), mk_op2(0, 5, 3, 1'b0, 8'h00), 4'h0, 1, 1, 0, "seg");
    // R6 R9: top-level region table, local flush
    run_cmd(mk_op1(64'h0000_0000_0010_0000, 3), mk_op2(3, 11'h123, 2, 1'b0, 8'h00), 4'h1, 1, 1, 0, "rgn1");
    // R6 R9: second-level region, local requested but feature disabled
    run_cmd(mk_op1(64'h0000_0000_0020_0000, 2), mk_op2(2, 11'h456, 2, 1'b0, 8'h00), 4'hF, 1, 0, 0, "rgn2");
    // R6 R7: third-level region, index wraps past 2047
    run_cmd(mk_op1(64'h0000_0000_0030_0000, 1), mk_op2(1, 11'h7FE, 4, 1'b0, 8'h00), 4'h0, 1, 1, 0, "rgn3wrap");
    // R4: walk suppressed, flush only
    run_cmd(mk_op1(64'h0000_0000_0040_0000, 0), mk_op2(0, 7, 9, 1'b1, 8'h00), 4'h1, 1, 1, 0, "flushonly");
    // R2: reserved bits set
    run_cmd(mk_op1(64'h0000_0000_0050_0000, 0), mk_op2(0, 7, 9, 1'b0, 8'h01), 4'h0, 1, 1, 0, "rsvd");
    run_cmd(mk_op1(64'h0000_0000_0050_0000, 0), mk_op2(0, 7, 9, 1'b1, 8'h80), 4'h1, 1, 1, 0, "rsvdhi");
    // R3: not privileged
    run_cmd(mk_op1(64'h0000_0000_0060_0000, 0), mk_op2(0, 7, 9, 1'b0, 8'h00), 4'h0, 0, 1, 0, "nopriv");
    // R11: stray start during a walk
    run_cmd(mk_op1(64'h0000_0000_0070_0000, 2), mk_op2(2, 11'h010, 7, 1'b0, 8'h00), 4'h0, 1, 1, 1, "poke");
    // R5 R7: full 2048-entry walk over an origin above 4 GiB
    run_cmd(mk_op1(64'h0000_0012_3456_7000, 0), mk_op2(0, 11'h100, 11'h7FF, 1'b0, 8'h00), 4'h1, 1, 1, 0, "full");
    // R8: second pass over invalidated entries reads only
    run_cmd(mk_op1(64'h0000_0000_0004_0000, 0), mk_op2(0, 5, 3, 1'b0, 8'h00), 4'h0, 1, 1, 0, "again");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule